// File: doc/BRIEF.md
# Receive FIFO with Trigger Level and Character Timeout

This block holds received bytes for a 16550-style serial receiver. Bytes arrive from the bit-level deserializer on a one-cycle push strobe. The host side removes them with a one-cycle pop strobe that accompanies a read of the receive data register. The head byte sits on a combinational output, so it is valid in the same cycle as the pop.

A FIFO-control write selects the mode. With FIFOs enabled, up to 16 bytes are queued. A trigger output goes high once the fill reaches a programmed level. If data sits unserviced for four character times, a timeout-pending flag is raised. With FIFOs disabled, the block acts as a single holding register.

The block also reports the line-status flags that belong to the receive path: data ready, overrun and break. A read of the line-status register clears the overrun and break flags. The character-time tick comes from outside, one pulse per frame time. The deserializer, baud generation and interrupt prioritisation live elsewhere.

Top module: `rx_fifo_trig`

## Requirements
- R1: After reset, every status output is 0, the retained control value is 0x00 (FIFOs disabled), the fill level is 0 and the transmit-flush pulse is low.
- R2: A control write keeps only bits 7, 6, 3 and 0 of the written byte (mask 0xC9) on `ctrlValue`. Bit 1 flushes the receive FIFO. Bit 2 raises `txFlush` for the following cycle. A write whose bit 0 differs from the current enable flushes the receive side and also raises `txFlush`.
- R3: With bit 0 set (FIFO mode), bytes leave in push order. `popData` shows the head byte combinationally, and 0x00 when empty. `dataReady` is 1 exactly when the fill level is non-zero. A push and a pop in the same cycle are both honoured.
- R4: Control bits 7:6 codes 00, 01, 10 and 11 set trigger levels of 1, 4, 8 and 14 bytes. In FIFO mode, `trigHit` is 1 while the fill level is at or above the selected level.
- R5: In FIFO mode, a push into a full FIFO with no pop in the same cycle drops the incoming byte, keeps the stored bytes and sets `overrun`.
- R6: With FIFOs disabled, a push overwrites the single holding register and sets `dataReady`. If `dataReady` was already 1 and no pop occurs in that cycle, the push also sets `overrun`. A pop clears `dataReady`, `popData` shows the holding register, and `trigHit` follows `dataReady`.
- R7: A break event is a push of 0x00 under the same overrun rules. It also sets `breakFlag` and `dataReady`. It takes precedence over a data push in the same cycle.
- R8: `lsrRead` clears `breakFlag` and `overrun`. A flag being set in the same cycle wins over the clear.
- R9: A pop that leaves the receive side empty, with no push in the same cycle, clears `dataReady` and `breakFlag`.
- R10: In FIFO mode, every push, and every pop that leaves data behind, restarts a four-tick timeout. On the fourth `charTick` with no push or pop in between, `timeoutPend` is set if data is present.
- R11: A pop clears `timeoutPend`. A pop that empties the FIFO cancels the running timeout.
- R12: A receive flush empties the FIFO and clears `dataReady`, `breakFlag` and `timeoutPend`. It cancels the timeout and leaves `overrun` unchanged. A push, pop or break in the flush cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Deserializer delivers a byte this cycle |
| pushData | input | 8 | Received byte |
| breakIn | input | 1 | Break condition detected this cycle |
| popReq | input | 1 | Receive data register read this cycle |
| popData | output | 8 | Byte returned by the read (combinational) |
| ctrlWr | input | 1 | FIFO-control register write strobe |
| ctrlData | input | 8 | FIFO-control write value |
| lsrRead | input | 1 | Line-status register read this cycle |
| charTick | input | 1 | One pulse per character time |
| ctrlValue | output | 8 | Retained FIFO-control bits |
| txFlush | output | 1 | One-cycle transmit FIFO flush request |
| fillLevel | output | 5 | Bytes held in the FIFO |
| dataReady | output | 1 | Receive data available |
| overrun | output | 1 | A byte was lost |
| breakFlag | output | 1 | A break was received |
| trigHit | output | 1 | Fill level reached the trigger level |
| timeoutPend | output | 1 | Character timeout expired with data present |

## Verification
The embedded properties assume that every input strobe has a known value in each cycle after reset, and that `DEPTH` is a power of two of at least 16. They also assume a timeout of at least two ticks. The bench drives every input to a defined level on the falling edge, away from the sampling edge. Besides directed sequences, it runs a long stretch of mixed traffic in which push, pop, break, status read, tick and occasional control writes collide in the same cycle. This covers the same-cycle priorities that the properties and the reference model rely on.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic       flush;
    logic       wrEn;
    logic       rdEn;
    logic       holdWr;
    logic [7:0] wrByte;
  } rxf_strobe_t;

  // Trigger threshold selected by control bits 7:6
  function automatic logic [4:0] trig_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      default: return 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/rxf_data.sv
module rxf_data
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rxf_strobe_t                  strb,
  input  logic                         fifoMode,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic [7:0]                   popData
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [7:0]    holdReg;

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrPtr] <= strb.wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      holdReg <= '0;
    end else begin
      if (strb.holdWr) holdReg <= strb.wrByte;
      if (strb.flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
        level <= '0;
      end else begin
        if (strb.wrEn) wrPtr <= wrPtr + 1'b1;
        if (strb.rdEn) rdPtr <= rdPtr + 1'b1;
        case ({strb.wrEn, strb.rdEn})
          2'b10:   level <= level + 1'b1;
          2'b01:   level <= level - 1'b1;
          default: level <= level;
        endcase
      end
    end
  end

  always_comb begin
    if (!fifoMode)         popData = holdReg;
    else if (level != '0)  popData = mem[rdPtr];
    else                   popData = 8'h00;
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= LW'(DEPTH));
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |-> level != '0);
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        pushValid,
  input  logic [7:0]                  pushData,
  input  logic                        breakIn,
  input  logic                        popReq,
  input  logic                        ctrlWr,
  input  logic [7:0]                  ctrlData,
  input  logic                        lsrRead,
  input  logic                        charTick,
  input  logic [$clog2(DEPTH+1)-1:0]  level,
  output rxf_strobe_t                 strb,
  output logic                        fifoMode,
  output logic [7:0]                  ctrlValue,
  output logic                        txFlush,
  output logic                        dataReady,
  output logic                        overrun,
  output logic                        breakFlag,
  output logic                        trigHit,
  output logic                        timeoutPend
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(TIMEOUT_CHARS);
  localparam logic [TW-1:0] LAST_TICK = TW'(TIMEOUT_CHARS - 1);

  logic          modeChange, flushNow, anyPush, anyPop;
  logic          notEmpty, isFull, doRd, doWr, ovSet, empties, restart, expire;
  logic          armed;
  logic [TW-1:0] tickCnt;
  logic [LW-1:0] trigLevel;

  assign fifoMode   = ctrlValue[0];
  assign modeChange = ctrlData[0] != ctrlValue[0];
  assign flushNow   = ctrlWr && (ctrlData[1] || modeChange);
  assign anyPush    = (pushValid || breakIn) && !flushNow;
  assign anyPop     = popReq && !flushNow;
  assign notEmpty   = level != '0;
  assign isFull     = level == LW'(DEPTH);
  assign doRd       = fifoMode && anyPop && notEmpty;
  assign doWr       = fifoMode && anyPush && (!isFull || doRd);
  assign ovSet      = anyPush && (fifoMode ? !doWr : (dataReady && !anyPop));
  assign empties    = anyPop && !anyPush && (fifoMode ? (level <= LW'(1)) : 1'b1);
  assign restart    = fifoMode && (anyPush || (doRd && level > LW'(1)));
  assign expire     = armed && charTick && (tickCnt == LAST_TICK) && !anyPush && !anyPop && !flushNow;
  assign trigLevel  = LW'(trig_bytes(ctrlValue[7:6]));
  assign trigHit    = fifoMode ? (level >= trigLevel) : dataReady;

  always_comb begin
    strb.flush  = flushNow;
    strb.wrEn   = doWr;
    strb.rdEn   = doRd;
    strb.holdWr = !fifoMode && anyPush;
    strb.wrByte = breakIn ? 8'h00 : pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlValue   <= '0;
      txFlush     <= 1'b0;
      dataReady   <= 1'b0;
      overrun     <= 1'b0;
      breakFlag   <= 1'b0;
      timeoutPend <= 1'b0;
      armed       <= 1'b0;
      tickCnt     <= '0;
    end else begin
      if (ctrlWr) ctrlValue <= ctrlData & 8'hC9;
      txFlush <= ctrlWr && (ctrlData[2] || modeChange);

      if (flushNow)     dataReady <= 1'b0;
      else if (anyPush) dataReady <= 1'b1;
      else if (empties) dataReady <= 1'b0;

      if (flushNow)                 breakFlag <= 1'b0;
      else if (breakIn)             breakFlag <= 1'b1;
      else if (lsrRead || empties)  breakFlag <= 1'b0;

      if (ovSet)        overrun <= 1'b1;
      else if (lsrRead) overrun <= 1'b0;

      if (flushNow || anyPop) timeoutPend <= 1'b0;
      else if (expire && notEmpty) timeoutPend <= 1'b1;

      if (flushNow) begin
        armed   <= 1'b0;
        tickCnt <= '0;
      end else if (restart) begin
        armed   <= 1'b1;
        tickCnt <= '0;
      end else if (anyPop) begin
        armed   <= 1'b0;
      end else if (armed && charTick) begin
        if (tickCnt == LAST_TICK) begin
          armed   <= 1'b0;
          tickCnt <= '0;
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
    end
  end

  // R3
  dr_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoMode |-> dataReady == (level != '0));
  // R11
  pend_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPend |-> (fifoMode && level != '0));
  // R12
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushNow |=> (!dataReady && !timeoutPend && !breakFlag && level == '0));
  // R5
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (anyPush && fifoMode && isFull && !anyPop) |=> (overrun && level == LW'(DEPTH)));
endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig
  import rxf_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TIMEOUT_CHARS = 4,
  localparam int LW           = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushValid,
  input  logic [7:0]    pushData,
  input  logic          breakIn,
  input  logic          popReq,
  output logic [7:0]    popData,
  input  logic          ctrlWr,
  input  logic [7:0]    ctrlData,
  input  logic          lsrRead,
  input  logic          charTick,
  output logic [7:0]    ctrlValue,
  output logic          txFlush,
  output logic [LW-1:0] fillLevel,
  output logic          dataReady,
  output logic          overrun,
  output logic          breakFlag,
  output logic          trigHit,
  output logic          timeoutPend
);
  rxf_strobe_t strb;
  logic        fifoMode;

  rxf_ctrl #(.DEPTH(DEPTH), .TIMEOUT_CHARS(TIMEOUT_CHARS)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .pushValid(pushValid), .pushData(pushData), .breakIn(breakIn),
    .popReq(popReq), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .lsrRead(lsrRead), .charTick(charTick), .level(fillLevel),
    .strb(strb), .fifoMode(fifoMode), .ctrlValue(ctrlValue),
    .txFlush(txFlush), .dataReady(dataReady), .overrun(overrun),
    .breakFlag(breakFlag), .trigHit(trigHit), .timeoutPend(timeoutPend)
  );

  rxf_data #(.DEPTH(DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .fifoMode(fifoMode),
    .level(fillLevel), .popData(popData)
  );
endmodule

// File: tb/rx_fifo_trig_tb_top.sv
module rx_fifo_trig_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       pushValid, breakIn, popReq, ctrlWr, lsrRead, charTick;
  logic [7:0] pushData, ctrlData;
  logic [7:0] popData, ctrlValue;
  logic [4:0] fillLevel;
  logic       txFlush, dataReady, overrun, breakFlag, trigHit, timeoutPend;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";

  // reference model state
  logic [7:0] q[$];
  logic [7:0] mHold = 8'h00, mCtrl = 8'h00;
  bit mDr, mOv, mBi, mPend, mArm, mTx;
  int mCnt;

  always #4 clk = ~clk;

  rx_fifo_trig dut_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .breakIn(breakIn), .popReq(popReq), .popData(popData),
    .ctrlWr(ctrlWr), .ctrlData(ctrlData), .lsrRead(lsrRead),
    .charTick(charTick), .ctrlValue(ctrlValue), .txFlush(txFlush),
    .fillLevel(fillLevel), .dataReady(dataReady), .overrun(overrun),
    .breakFlag(breakFlag), .trigHit(trigHit), .timeoutPend(timeoutPend)
  );

  task automatic cmp(string what, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s, phase %s) actual %h expected %h", req, what, curReq, act, exp);
    end
  endtask

  function automatic int trigOf(logic [1:0] c);
    case (c)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic cmpAll();
    bit expTrig;
    expTrig = mCtrl[0] ? (q.size() >= trigOf(mCtrl[7:6])) : mDr;
    cmp("dataReady",   "R3",  {7'b0, dataReady},   {7'b0, mDr});
    cmp("overrun",     "R5",  {7'b0, overrun},     {7'b0, mOv});
    cmp("breakFlag",   "R7",  {7'b0, breakFlag},   {7'b0, mBi});
    cmp("timeoutPend", "R10", {7'b0, timeoutPend}, {7'b0, mPend});
    cmp("trigHit",     "R4",  {7'b0, trigHit},     {7'b0, expTrig});
    cmp("fillLevel",   "R3",  {3'b0, fillLevel},   8'(q.size()));
    cmp("ctrlValue",   "R2",  ctrlValue,           mCtrl);
    cmp("txFlush",     "R2",  {7'b0, txFlush},     {7'b0, mTx});
  endtask

  task automatic step(bit pv, logic [7:0] pd, bit brk, bit pop, bit cw,
                      logic [7:0] cd, bit lsr, bit tick);
    bit mf, fl, pu, po, ovs, emp;
    logic [7:0] b, expPop;
    pushValid = pv; pushData = pd; breakIn = brk; popReq = pop;
    ctrlWr = cw; ctrlData = cd; lsrRead = lsr; charTick = tick;
    #1;
    expPop = mCtrl[0] ? ((q.size() > 0) ? q[0] : 8'h00) : mHold;
    cmp("popData", "R3", popData, expPop);
    @(posedge clk);
    mf  = mCtrl[0];
    fl  = cw && (cd[1] || (cd[0] != mCtrl[0]));
    pu  = (pv || brk) && !fl;
    po  = pop && !fl;
    b   = brk ? 8'h00 : pd;
    ovs = 0; emp = 0;
    mTx = cw && (cd[2] || (cd[0] != mCtrl[0]));
    if (cw) mCtrl = cd & 8'hC9;
    if (fl) begin
      q.delete(); mDr = 0; mBi = 0; mPend = 0; mArm = 0; mCnt = 0;
    end else if (mf) begin
      if (po && q.size() > 0) void'(q.pop_front());
      if (pu) begin
        if (q.size() < 16) q.push_back(b); else ovs = 1;
      end
      mDr = q.size() > 0;
      if (po) mPend = 0;
      if (pu || (po && q.size() > 0)) begin mArm = 1; mCnt = 0; end
      else if (po) mArm = 0;
      else if (mArm && tick) begin
        mCnt++;
        if (mCnt == 4) begin
          mArm = 0; mCnt = 0;
          if (q.size() > 0) mPend = 1;
        end
      end
      emp = po && q.size() == 0;
    end else begin
      if (pu) begin
        if (mDr && !po) ovs = 1;
        mHold = b; mDr = 1;
      end else if (po) mDr = 0;
      emp = po && !pu;
    end
    if (!fl) begin
      if (brk) mBi = 1;
      else if (lsr || emp) mBi = 0;
    end
    if (ovs) mOv = 1; else if (lsr) mOv = 0;
    @(negedge clk);
    cmpAll();
  endtask

  task automatic idle(int n = 1);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 8'h00, 0, 0);
  endtask
  task automatic push(logic [7:0] d); step(1, d, 0, 0, 0, 8'h00, 0, 0); endtask
  task automatic popOne();            step(0, 8'h00, 0, 1, 0, 8'h00, 0, 0); endtask
  task automatic wrCtrl(logic [7:0] d); step(0, 8'h00, 0, 0, 1, d, 0, 0); endtask
  task automatic lsrRd();             step(0, 8'h00, 0, 0, 0, 8'h00, 1, 0); endtask
  task automatic brkIn();             step(0, 8'h00, 1, 0, 0, 8'h00, 0, 0); endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 8'h00, 0, 1);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired in phase %s", curReq);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    {pushValid, breakIn, popReq, ctrlWr, lsrRead, charTick} = '0;
    pushData = '0; ctrlData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    cmpAll();
    idle(2);

    // Single holding register mode
    curReq = "R6";
    push(8'h41); popOne(); push(8'h42); push(8'h43); popOne();
    curReq = "R8";
    lsrRd();
    push(8'h44); step(1, 8'h45, 0, 1, 0, 8'h00, 0, 0); popOne();

    // Enable FIFOs, all bits set: mask, flush, tx pulse
    curReq = "R2";
    wrCtrl(8'hFF); idle(1);
    wrCtrl(8'h05); idle(1);

    // Fill to full with trigger at 14, drain, pop when empty
    curReq = "R4";
    wrCtrl(8'hC1);
    for (int i = 0; i < 16; i++) push(8'(8'h10 + i));
    curReq = "R5";
    push(8'hEE); push(8'hEF);
    step(1, 8'h77, 0, 1, 0, 8'h00, 0, 0);
    curReq = "R8";
    lsrRd();
    curReq = "R3";
    for (int i = 0; i < 17; i++) popOne();

    // Other trigger levels
    curReq = "R4";
    for (int c = 0; c < 3; c++) begin
      wrCtrl(8'(c << 6) | 8'h03);
      for (int i = 0; i < 9; i++) push(8'(8'h60 + i));
    end

    // Timeout
    curReq = "R10";
    wrCtrl(8'h03);
    push(8'h31); ticks(3); push(8'h32); ticks(3); ticks(2);
    curReq = "R11";
    popOne(); ticks(5); popOne(); ticks(5);

    // Break and emptying pop
    curReq = "R7";
    push(8'h99); brkIn(); lsrRd();
    step(1, 8'h55, 1, 0, 0, 8'h00, 0, 0);
    curReq = "R9";
    popOne(); popOne(); popOne(); popOne();

    // Flush with pending timeout and concurrent traffic
    curReq = "R12";
    push(8'h01); push(8'h02); brkIn(); ticks(4);
    step(1, 8'hAB, 1, 1, 1, 8'h03, 0, 1);
    push(8'h03); ticks(4);
    step(1, 8'hCD, 0, 0, 1, 8'h02, 0, 0);
    idle(2);

    // Mixed traffic
    curReq = "R3";
    for (int i = 0; i < 3000; i++) begin
      bit cw;
      logic [7:0] cd;
      cw = ($urandom_range(0, 99) == 0);
      cd = 8'($urandom_range(0, 255));
      if (cw && $urandom_range(0, 3) != 0) cd[0] = mCtrl[0];
      step($urandom_range(0, 2) == 0, 8'($urandom_range(0, 255)),
           $urandom_range(0, 30) == 0, $urandom_range(0, 3) == 0,
           cw, cd, $urandom_range(0, 15) == 0, $urandom_range(0, 3) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule